// File: doc/BRIEF.md
# Two-Port GPIO Register Bank

This block holds the control state for sixteen general-purpose pins, arranged as two ports of eight. A host reaches it over a byte-wide interface. A command strobe loads a register pointer. Data-byte writes and reads then go to the register that the pointer selects. There are four register pairs, one register per port in each pair:

- sampled pin levels,
- stored output values,
- read-side polarity inversion,
- pin direction.

For every pin the block produces an output value and an output enable. It takes the pin levels back in through a resynchronizing flop chain.

After every data byte, the pointer moves to the other register of the same pair. A host can therefore move both ports of one register pair as a two-byte burst, and any further bytes alternate between the two. Read data is registered: it appears on the cycle after the read strobe and stays there until the next read.

Top module: `gpio_bank`

## Requirements
- R1: Reset state. Output registers hold 0xFF, polarity registers hold 0x00, direction registers hold 0xFF, and the pointer selects index 0. As a result pin_oe is all zeros and pin_out is all ones after reset.
- R2: A command strobe whose value is below 8 loads the pointer from cmd[2:0]. The register indices are 0/1 input port 0/1, 2/3 output port 0/1, 4/5 polarity port 0/1, and 6/7 direction port 0/1.
- R3: A command strobe with any of cmd[7:3] set is ignored, and the pointer keeps its value.
- R4: Each accepted data read or write inverts bit 0 of the pointer and leaves bits 2:1 alone. The bench relies on this, for example to read 2 → 3 → 2.
- R5: Reading index 0 or 1 returns the synchronized pin levels of that port XOR that port's polarity bits. This holds for pins in either direction. A pin change becomes readable on the second clock edge after it is applied.
- R6: Writing index 0 or 1 changes no register. Only the pointer advances, as in R4.
- R7: Reading index 2 or 3 returns the stored output value, not the pin level.
- R8: pin_oe[i] is the inverse of direction bit i, so a 1 means input with the driver off. pin_out[i] is the stored output bit, and it reaches the pin only where pin_oe[i] is 1.
- R9: rd_data shows the selected register one cycle after rd_en and holds that value until the next accepted read.
- R10: When cmd_wr is high, a wr_en or rd_en in the same cycle is discarded. No register, no rd_data value and no pointer toggle results from it.
- R11: Reading index 4 to 7 returns the stored polarity or direction byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command strobe: load pointer from cmd |
| cmd | input | 8 | Command byte |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | PORT_W | Data byte to write |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | PORT_W | Registered read data |
| pin_in | input | 2*PORT_W | Pin levels, asynchronous |
| pin_out | output | 2*PORT_W | Per-pin output value |
| pin_oe | output | 2*PORT_W | Per-pin output enable, 1 drives |

## Verification
The bench builds the block with its defaults: eight-bit ports and a two-stage synchronizer. At these values every register value used in the tests fits in one byte and is easy to check by eye. The two-edge pin latency can also be caught exactly, by a read issued one cycle after a pin change that still returns the old level. Pointer wrap within a pair, ignored out-of-range commands and command/data collisions are each driven as directed sequences. In every case the result is observed through rd_data, pin_out and pin_oe.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int CMD_W = 8;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_IN0  = 3'd0,
        SEL_IN1  = 3'd1,
        SEL_OUT0 = 3'd2,
        SEL_OUT1 = 3'd3,
        SEL_POL0 = 3'd4,
        SEL_POL1 = 3'd5,
        SEL_CFG0 = 3'd6,
        SEL_CFG1 = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        GRP_IN  = 2'd0,
        GRP_OUT = 2'd1,
        GRP_POL = 2'd2,
        GRP_CFG = 2'd3
    } reg_grp_e;

    typedef struct packed {
        logic cmd_ld;
        logic wr;
        logic rd;
    } host_op_t;

    function automatic logic cmd_in_range(logic [CMD_W-1:0] c);
        return c[CMD_W-1:SEL_W] == '0;
    endfunction

    function automatic reg_grp_e sel_group(reg_sel_e s);
        return reg_grp_e'(s[SEL_W-1:1]);
    endfunction

    function automatic logic sel_port(reg_sel_e s);
        return s[0];
    endfunction

    function automatic reg_sel_e sel_partner(reg_sel_e s);
        return reg_sel_e'({s[SEL_W-1:1], ~s[0]});
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[LAST];
endmodule

// File: rtl/gpio_cmd_ptr.sv
module gpio_cmd_ptr
    import gpio_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  host_op_t         op,
    input  logic [CMD_W-1:0] cmd,
    output reg_sel_e         ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= SEL_IN0;
        end else if (op.cmd_ld) begin
            if (cmd_in_range(cmd)) ptr <= reg_sel_e'(cmd[SEL_W-1:0]);
        end else if (op.wr || op.rd) begin
            ptr <= sel_partner(ptr);
        end
    end

    // R3: an out-of-range command leaves the pointer alone
    assert_bad_cmd_keeps_ptr_R3: assert property (@(posedge clk) disable iff (rst)
        (op.cmd_ld && cmd[CMD_W-1:SEL_W] != '0) |=> $stable(ptr));

    // R4: a data access flips only the port bit
    assert_ptr_pair_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (!op.cmd_ld && (op.wr || op.rd)) |=>
            (ptr[SEL_W-1:1] == $past(ptr[SEL_W-1:1])) && (ptr[0] != $past(ptr[0])));

    // R2: an in-range command lands in the pointer
    assert_cmd_loads_ptr_R2: assert property (@(posedge clk) disable iff (rst)
        (op.cmd_ld && cmd[CMD_W-1:SEL_W] == '0) |=> (ptr == $past(cmd[SEL_W-1:0])));
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_stb,
    input  reg_sel_e              wr_sel,
    input  logic [PORT_W-1:0]     wr_data,
    output logic [2*PORT_W-1:0]   out_q,
    output logic [2*PORT_W-1:0]   pol_q,
    output logic [2*PORT_W-1:0]   cfg_q
);
    localparam int NPORT = 2;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [PORT_W-1:0] out_r, pol_r, cfg_r;
        logic              hit;

        assign hit = wr_stb && (sel_port(wr_sel) == 1'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                out_r <= '1;
                pol_r <= '0;
                cfg_r <= '1;
            end else if (hit) begin
                case (sel_group(wr_sel))
                    GRP_OUT: out_r <= wr_data;
                    GRP_POL: pol_r <= wr_data;
                    GRP_CFG: cfg_r <= wr_data;
                    default: ;
                endcase
            end
        end

        assign out_q[p*PORT_W +: PORT_W] = out_r;
        assign pol_q[p*PORT_W +: PORT_W] = pol_r;
        assign cfg_q[p*PORT_W +: PORT_W] = cfg_r;
    end

    // R6: a write aimed at the input pair changes no storage
    assert_input_write_inert_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && sel_group(wr_sel) == GRP_IN) |=>
            ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_bank_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_stb,
    input  reg_sel_e              rd_sel,
    input  logic [2*PORT_W-1:0]   sync_in,
    input  logic [2*PORT_W-1:0]   out_q,
    input  logic [2*PORT_W-1:0]   pol_q,
    input  logic [2*PORT_W-1:0]   cfg_q,
    output logic [PORT_W-1:0]     rd_data
);
    logic [PORT_W-1:0] pin_b, out_b, pol_b, cfg_b, sel_b;

    always_comb begin
        if (sel_port(rd_sel)) begin
            pin_b = sync_in[2*PORT_W-1:PORT_W];
            out_b = out_q[2*PORT_W-1:PORT_W];
            pol_b = pol_q[2*PORT_W-1:PORT_W];
            cfg_b = cfg_q[2*PORT_W-1:PORT_W];
        end else begin
            pin_b = sync_in[PORT_W-1:0];
            out_b = out_q[PORT_W-1:0];
            pol_b = pol_q[PORT_W-1:0];
            cfg_b = cfg_q[PORT_W-1:0];
        end
        case (sel_group(rd_sel))
            GRP_IN:  sel_b = pin_b ^ pol_b;
            GRP_OUT: sel_b = out_b;
            GRP_POL: sel_b = pol_b;
            default: sel_b = cfg_b;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (rd_stb) rd_data <= sel_b;
    end

    // R9: read data holds between accepted reads
    assert_rd_data_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));

    // R7: output-group reads follow the stored byte, whatever the pins do
    assert_out_read_from_flop_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_sel == SEL_OUT0) |=> (rd_data == $past(out_q[PORT_W-1:0])));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_wr,
    input  logic [CMD_W-1:0]      cmd,
    input  logic                  wr_en,
    input  logic [PORT_W-1:0]     wr_data,
    input  logic                  rd_en,
    output logic [PORT_W-1:0]     rd_data,
    input  logic [2*PORT_W-1:0]   pin_in,
    output logic [2*PORT_W-1:0]   pin_out,
    output logic [2*PORT_W-1:0]   pin_oe
);
    localparam int PINS = 2 * PORT_W;

    host_op_t         op;
    reg_sel_e         ptr;
    logic [PINS-1:0]  sync_in;
    logic [PINS-1:0]  out_q, pol_q, cfg_q;

    // a command strobe takes the cycle; data strobes beside it are dropped
    assign op.cmd_ld = cmd_wr;
    assign op.wr     = wr_en && !cmd_wr;
    assign op.rd     = rd_en && !cmd_wr;

    gpio_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_in)
    );

    gpio_cmd_ptr u_ptr (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .cmd (cmd),
        .ptr (ptr)
    );

    gpio_reg_file #(.PORT_W(PORT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (op.wr),
        .wr_sel  (ptr),
        .wr_data (wr_data),
        .out_q   (out_q),
        .pol_q   (pol_q),
        .cfg_q   (cfg_q)
    );

    gpio_read_mux #(.PORT_W(PORT_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_stb  (op.rd),
        .rd_sel  (ptr),
        .sync_in (sync_in),
        .out_q   (out_q),
        .pol_q   (pol_q),
        .cfg_q   (cfg_q),
        .rd_data (rd_data)
    );

    assign pin_out = out_q;
    assign pin_oe  = ~cfg_q;

    // R8: a direction write on port 0 shows up inverted on the enables
    assert_dir_write_drives_oe_R8: assert property (@(posedge clk) disable iff (rst)
        (op.wr && ptr == SEL_CFG0) |=> (pin_oe[PORT_W-1:0] == ~$past(wr_data)));

    // R10: a command cycle changes no pin-facing state and no read data
    assert_cmd_cycle_blocks_data_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> ($stable(pin_out) && $stable(pin_oe) && $stable(rd_data)));

    // R1: first cycle after reset shows all pins as inputs
    assert_reset_pins_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (pin_oe == '0 && pin_out == '1));
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    localparam int CLK_PERIOD = 10;
    localparam int PORT_W     = 8;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cmd_wr = 1'b0;
    logic [7:0]          cmd = '0;
    logic                wr_en = 1'b0;
    logic [PORT_W-1:0]   wr_data = '0;
    logic                rd_en = 1'b0;
    logic [PORT_W-1:0]   rd_data;
    logic [2*PORT_W-1:0] pin_in = 16'hA55A;
    logic [2*PORT_W-1:0] pin_out, pin_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank #(.PORT_W(PORT_W), .SYNC_STAGES(2)) i_gpio_bank (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd(cmd), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_cmd(input logic [7:0] c);
        @(negedge clk); cmd_wr = 1'b1; cmd = c;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic do_wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_rd(output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        chk("R1 pin_oe after reset", pin_oe, 16'h0000);
        chk("R1 pin_out after reset", pin_out, 16'hFFFF);
        chk("R1 rd_data after reset", 16'(rd_data), 16'h0000);
        repeat (3) @(negedge clk);
        do_rd(d); chk("R1 R5 pointer at input port 0", 16'(d), 16'h005A);
        do_rd(d); chk("R4 toggles to input port 1", 16'(d), 16'h00A5);
    endtask

    task automatic t_reg_rw();
        logic [7:0] d;
        do_cmd(8'h02); do_wr(8'h12); do_wr(8'h34);
        do_cmd(8'h02);
        do_rd(d); chk("R2 output port 0", 16'(d), 16'h0012);
        do_rd(d); chk("R4 burst to output port 1", 16'(d), 16'h0034);
        do_rd(d); chk("R4 wraps back to port 0", 16'(d), 16'h0012);
        do_cmd(8'h05); do_wr(8'h0F); do_wr(8'h00);
        do_cmd(8'h04);
        do_rd(d); chk("R11 polarity port 0", 16'(d), 16'h0000);
        do_rd(d); chk("R11 polarity port 1", 16'(d), 16'h000F);
        do_cmd(8'h06); do_wr(8'hF0); do_wr(8'hC3);
        do_cmd(8'h06);
        do_rd(d); chk("R11 direction port 0", 16'(d), 16'h00F0);
        do_rd(d); chk("R11 direction port 1", 16'(d), 16'h00C3);
    endtask

    task automatic t_outputs();
        logic [7:0] d;
        @(negedge clk);
        chk("R8 pin_oe is inverse direction", pin_oe, 16'h3C0F);
        chk("R8 pin_out is stored value", pin_out, 16'h3412);
        do_cmd(8'h00);
        do_rd(d); chk("R5 output-mode pins still read", 16'(d), 16'h005A);
        do_rd(d); chk("R5 port 1 with polarity", 16'(d), 16'h00AA);
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        do_cmd(8'h02);
        do_rd(d); chk("R7 output read ignores pins", 16'(d), 16'h0012);
    endtask

    task automatic t_polarity();
        logic [7:0] d;
        do_cmd(8'h04); do_wr(8'hFF); do_wr(8'h0F);
        pin_in = 16'h3CC3;
        repeat (3) @(negedge clk);
        do_cmd(8'h00);
        do_rd(d); chk("R5 inverted port 0", 16'(d), 16'h003C);
        do_rd(d); chk("R5 half-inverted port 1", 16'(d), 16'h0033);
        // latency: a read one edge after a pin change still sees the old level
        do_cmd(8'h00);
        pin_in = 16'h0000;
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
        chk("R5 second-edge latency old", 16'(d), 16'h003C);
        do_cmd(8'h00);
        do_rd(d); chk("R5 second-edge latency new", 16'(d), 16'h00FF);
    endtask

    task automatic t_input_ro();
        logic [7:0] d;
        do_cmd(8'h01); do_wr(8'h55);
        @(negedge clk);
        chk("R6 pin_out unchanged", pin_out, 16'h3412);
        chk("R6 pin_oe unchanged", pin_oe, 16'h3C0F);
        do_rd(d); chk("R6 pointer advanced to input 0", 16'(d), 16'h00FF);
        do_cmd(8'h04);
        do_rd(d); chk("R6 polarity 0 unchanged", 16'(d), 16'h00FF);
        do_rd(d); chk("R6 polarity 1 unchanged", 16'(d), 16'h000F);
    endtask

    task automatic t_bad_cmd();
        logic [7:0] d;
        do_cmd(8'h03); do_cmd(8'h0C); do_cmd(8'h80);
        do_rd(d); chk("R3 out-of-range commands ignored", 16'(d), 16'h0034);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        do_cmd(8'h02);
        @(negedge clk); cmd_wr = 1'b1; cmd = 8'h06; wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk); cmd_wr = 1'b0; wr_en = 1'b0;
        chk("R10 write beside command dropped", pin_oe, 16'h3C0F);
        do_rd(d); chk("R10 pointer not toggled", 16'(d), 16'h00F0);
        @(negedge clk); cmd_wr = 1'b1; cmd = 8'h00; rd_en = 1'b1;
        @(negedge clk); cmd_wr = 1'b0; rd_en = 1'b0;
        chk("R10 read beside command dropped", 16'(rd_data), 16'h00F0);
        do_rd(d); chk("R10 command still taken", 16'(d), 16'h00FF);
    endtask

    task automatic t_hold();
        repeat (4) @(negedge clk);
        chk("R9 rd_data holds without rd_en", 16'(rd_data), 16'h00FF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reg_rw();
        t_outputs();
        t_polarity();
        t_input_ro();
        t_bad_cmd();
        t_collide();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule